// File: doc/BRIEF.md
# DDR Bank Write-to-Precharge Timing Guard

This block sits beside the command scheduler of a DDR SDRAM controller. It watches the command stream that has already been issued, one command per clock with a target bank. For each bank it reports whether a precharge is legal now, and whether a fresh activate is legal now. It tracks three gaps: activate-to-precharge (tRAS), write recovery (tWR) and precharge-to-activate (tRP). All three are parameters counted in controller clocks. The model assumes one write data beat per controller clock. The beats of a write occupy the BURST_LEN cycles that begin right after the write edge.

A precharge can land on a bank while that bank's own plain write burst still has beats to send. The block treats this as a burst cut and does not flag it as a violation. From the cycle after the cut edge until the burst would have ended, it drives a data-mask output. The strobe-enable output stays high for the whole nominal burst, so the mask value is still captured. The bank then pays its write recovery before the activate gap begins.

A write with auto precharge has its own rule. The internal precharge starts at the later of two points: the end of write recovery for the full burst, or the end of tRAS. The activate window is placed tRP after that point. A new write may cut short a plain burst that is in flight. The recovery reference then moves to the newer burst's data. Commands that make no sense for a bank's open or closed state raise a one-cycle protocol error and change nothing.

Top module: `ddr_wr_pre_guard`

## Requirements
- R1: While `rst` is high on a clock edge, every bank is marked closed and every timer expires. After reset, `act_ok` is all ones and `pre_ok`, `dqs_en`, `dm` and `proto_err` are zero.
- R2: `cmd_op` encodes 0 = none, 1 = activate, 2 = write, 3 = write with auto precharge, 4 = precharge. An activate at edge a opens the bank and drops its `act_ok`. The bank's `pre_ok` stays low until the cycle before edge a+T_RAS. All flags come from registered state, so a flag seen just before edge e states legality for a command at edge e.
- R3: A write or auto-precharge write accepted at edge c holds `dqs_en` high for exactly BURST_LEN cycles, starting in the cycle right after edge c. `dm` stays low unless a cut occurs.
- R4: After a plain write at edge c that runs to completion, a precharge to that bank becomes legal only at edge c+BURST_LEN+T_WR, and never before tRAS is met.
- R5: A write at edge c2 cuts short a plain burst still in flight. The new burst starts at once. If the old burst was to another bank, that bank may be precharged from edge c2+T_WR. If it was to the same bank, recovery restarts as in R4 from c2.
- R6: A precharge at edge p to the bank whose plain burst still has beats after edge p is a cut. It is legal once tRAS is met. `dm` is high from the cycle after p until the burst's nominal end, and `dqs_en` keeps running over those masked beats.
- R7: A plain precharge at edge p closes the bank, and `act_ok` returns at edge p+T_RP. After a cut, `act_ok` returns at edge p+T_WR+T_RP.
- R8: A write with auto precharge at edge c, when R remaining tRAS cycles are left, closes the bank at once. A new activate is legal at edge c+max(BURST_LEN+T_WR, R)+T_RP.
- R9: Each of these commands raises `proto_err` for the one cycle after its edge and changes no bank state, flag or strobe: an activate to an open bank; a write, auto-precharge write or precharge to a closed bank; any write while an auto-precharge burst still has beats left.
- R10: `cmd_op` codes 5, 6 and 7 act as no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Command issued this cycle (encoding in R2) |
| cmd_bank | input | BANK_W | Target bank of the command |
| pre_ok | output | NUM_BANKS | Per bank: a precharge on the next edge is legal |
| act_ok | output | NUM_BANKS | Per bank: an activate on the next edge is legal |
| dqs_en | output | 1 | Write strobe enable for the current beat |
| dm | output | 1 | Data mask for the current beat (residual beats of a cut burst) |
| proto_err | output | 1 | Previous command was illegal for the bank state |

## Verification
The bench drives a run of command patterns and compares each one against a behavioural model every cycle. It first checks an uninterrupted write followed by a precharge at the earliest point, which isolates the plain tWR + tRAS gate. It then issues back-to-back writes to different banks and to the same bank, which tells the moved recovery reference apart from the restarted one. A precharge in the middle of a burst, followed by a write to another bank, separates masking from strobing and shows that a later burst clears the mask. Two auto-precharge writes are issued, one right after activate and one long after, so each side of the max(tWR path, tRAS) choice is exercised. Illegal commands and unused op codes are interleaved to confirm they change nothing.

// File: rtl/ddr_wpg_pkg.sv
package ddr_wpg_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_WR  = 3'd2,
        OP_WRA = 3'd3,
        OP_PRE = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        LANE_IDLE,
        LANE_STREAM,
        LANE_MASK,
        LANE_AUTO
    } lane_e;

    typedef enum logic {
        BK_SHUT,
        BK_LIVE
    } bank_e;

endpackage

// File: rtl/wpg_bank_timer.sv
module wpg_bank_timer
    import ddr_wpg_pkg::*;
#(
    parameter int BURST_LEN = 8,
    parameter int T_WR      = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic ev_act,
    input  logic ev_wr,
    input  logic ev_tail,
    input  logic ev_pre,
    input  logic ev_cut,
    input  logic ev_wra,
    input  logic in_window,
    output logic is_open,
    output logic pre_ok,
    output logic act_ok
);
    localparam int CW = $clog2(BURST_LEN + T_WR + T_RAS + T_RP + 1);
    localparam logic [CW-1:0] LD_RAS  = CW'(T_RAS - 1);
    localparam logic [CW-1:0] LD_WRF  = CW'(BURST_LEN + T_WR - 1);
    localparam logic [CW-1:0] LD_TAIL = CW'(T_WR - 1);
    localparam logic [CW-1:0] LD_RP   = CW'(T_RP - 1);
    localparam logic [CW-1:0] LD_CUT  = CW'(T_WR + T_RP - 1);
    localparam logic [CW-1:0] WR_SPAN = CW'(BURST_LEN + T_WR);

    bank_e          st;
    logic [CW-1:0]  ras_q, wr_q, rp_q;
    logic [CW-1:0]  span, wra_ld;

    // internal precharge of an auto-precharge write waits for the later of
    // full-burst recovery and the remaining activate-to-precharge time
    always_comb begin
        span   = (ras_q > WR_SPAN) ? ras_q : WR_SPAN;
        wra_ld = span + LD_RP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= BK_SHUT;
            ras_q <= '0;
            wr_q  <= '0;
            rp_q  <= '0;
        end else begin
            ras_q <= (ras_q == '0) ? '0 : ras_q - 1'b1;
            wr_q  <= (wr_q  == '0) ? '0 : wr_q  - 1'b1;
            rp_q  <= (rp_q  == '0) ? '0 : rp_q  - 1'b1;
            if (ev_act) begin
                st    <= BK_LIVE;
                ras_q <= LD_RAS;
                wr_q  <= '0;
            end
            if (ev_wr)   wr_q <= LD_WRF;
            if (ev_tail) wr_q <= LD_TAIL;
            if (ev_pre) begin
                st   <= BK_SHUT;
                rp_q <= ev_cut ? LD_CUT : LD_RP;
            end
            if (ev_wra) begin
                st   <= BK_SHUT;
                rp_q <= wra_ld;
            end
        end
    end

    always_comb begin
        is_open = (st == BK_LIVE);
        pre_ok  = is_open && (ras_q == '0) && ((wr_q == '0) || in_window);
        act_ok  = !is_open && (rp_q == '0);
    end

endmodule

// File: rtl/wpg_data_lane.sv
module wpg_data_lane
    import ddr_wpg_pkg::*;
#(
    parameter int BURST_LEN = 8,
    parameter int BANK_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_wr,
    input  logic              go_wra,
    input  logic              go_cut,
    input  logic [BANK_W-1:0] go_bank,
    output logic              dqs_en,
    output logic              dm,
    output logic              cut_window,
    output logic              auto_busy,
    output logic [BANK_W-1:0] lane_bank
);
    localparam int LW = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;
    localparam logic [LW-1:0] LAST = LW'(BURST_LEN - 1);

    lane_e            st, st_n;
    logic [LW-1:0]    left, left_n;
    logic [BANK_W-1:0] bank_q, bank_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= LANE_IDLE;
            left   <= '0;
            bank_q <= '0;
        end else begin
            st     <= st_n;
            left   <= left_n;
            bank_q <= bank_n;
        end
    end

    always_comb begin
        st_n   = st;
        left_n = left;
        bank_n = bank_q;
        if (go_wr || go_wra) begin
            st_n   = go_wr ? LANE_STREAM : LANE_AUTO;
            left_n = LAST;
            bank_n = go_bank;
        end else begin
            unique case (st)
                LANE_IDLE: begin
                end
                LANE_STREAM: begin
                    if (left == '0) begin
                        st_n = LANE_IDLE;
                    end else begin
                        left_n = left - 1'b1;
                        if (go_cut) st_n = LANE_MASK;
                    end
                end
                LANE_MASK, LANE_AUTO: begin
                    if (left == '0) st_n = LANE_IDLE;
                    else            left_n = left - 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        dqs_en     = (st != LANE_IDLE);
        dm         = (st == LANE_MASK);
        cut_window = (st == LANE_STREAM) && (left != '0);
        auto_busy  = (st == LANE_AUTO) && (left != '0);
        lane_bank  = bank_q;
    end

endmodule

// File: rtl/ddr_wr_pre_guard.sv
module ddr_wr_pre_guard
    import ddr_wpg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = $clog2(NUM_BANKS),
    parameter int BURST_LEN = 8,
    parameter int T_WR      = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           cmd_op,
    input  logic [BANK_W-1:0]    cmd_bank,
    output logic [NUM_BANKS-1:0] pre_ok,
    output logic [NUM_BANKS-1:0] act_ok,
    output logic                 dqs_en,
    output logic                 dm,
    output logic                 proto_err
);
    logic [NUM_BANKS-1:0] open_v;
    logic                 is_act, is_wr, is_wra, is_pre, sel_open;
    logic                 cmd_err, go_act, go_wr, go_wra, go_pre, go_cut, start_any;
    logic                 cut_window, auto_busy;
    logic [BANK_W-1:0]    lane_bank;

    always_comb begin
        is_act   = (cmd_op == OP_ACT);
        is_wr    = (cmd_op == OP_WR);
        is_wra   = (cmd_op == OP_WRA);
        is_pre   = (cmd_op == OP_PRE);
        sel_open = open_v[cmd_bank];
        cmd_err  = (is_act && sel_open)
                 || ((is_wr || is_wra || is_pre) && !sel_open)
                 || ((is_wr || is_wra) && auto_busy);
        go_act    = is_act && !cmd_err;
        go_wr     = is_wr  && !cmd_err;
        go_wra    = is_wra && !cmd_err;
        go_pre    = is_pre && !cmd_err;
        go_cut    = go_pre && cut_window && (lane_bank == cmd_bank);
        start_any = go_wr || go_wra;
    end

    always_ff @(posedge clk) begin
        if (rst) proto_err <= 1'b0;
        else     proto_err <= cmd_err;
    end

    wpg_data_lane #(
        .BURST_LEN (BURST_LEN),
        .BANK_W    (BANK_W)
    ) u_lane (
        .clk        (clk),
        .rst        (rst),
        .go_wr      (go_wr),
        .go_wra     (go_wra),
        .go_cut     (go_cut),
        .go_bank    (cmd_bank),
        .dqs_en     (dqs_en),
        .dm         (dm),
        .cut_window (cut_window),
        .auto_busy  (auto_busy),
        .lane_bank  (lane_bank)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit, mine;
        always_comb begin
            hit  = (cmd_bank == BANK_W'(b));
            mine = cut_window && (lane_bank == BANK_W'(b));
        end
        wpg_bank_timer #(
            .BURST_LEN (BURST_LEN),
            .T_WR      (T_WR),
            .T_RP      (T_RP),
            .T_RAS     (T_RAS)
        ) u_timer (
            .clk       (clk),
            .rst       (rst),
            .ev_act    (go_act && hit),
            .ev_wr     (go_wr && hit),
            .ev_tail   (start_any && mine && !hit),
            .ev_pre    (go_pre && hit),
            .ev_cut    (go_cut && hit),
            .ev_wra    (go_wra && hit),
            .in_window (mine),
            .is_open   (open_v[b]),
            .pre_ok    (pre_ok[b]),
            .act_ok    (act_ok[b])
        );
    end

endmodule

// File: rtl/ddr_wr_pre_guard_chk.sv
module ddr_wr_pre_guard_chk #(
    parameter int NB = 4,
    parameter int BW = 2,
    parameter int BL = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          dqs_en,
    input logic          dm,
    input logic          start_any,
    input logic          go_act,
    input logic [BW-1:0] cmd_bank,
    input logic [NB-1:0] open_v,
    input logic          proto_err
);
    logic [7:0] run;

    always_ff @(posedge clk) begin
        if (rst)            run <= '0;
        else if (start_any) run <= 8'd1;
        else if (dqs_en)    run <= (run == 8'hff) ? run : run + 8'd1;
        else                run <= '0;
    end

    // R3: a strobe run never outlasts one burst
    a_r3_strobe_run: assert property (@(posedge clk) disable iff (rst)
        dqs_en |-> (run != 8'd0 && run <= 8'(BL)));

    // R6: masked beats are always strobed
    a_r6_mask_in_strobe: assert property (@(posedge clk) disable iff (rst)
        dm |-> dqs_en);

    // R6: once masking starts it lasts to the burst end unless a new write arrives
    a_r6_mask_holds: assert property (@(posedge clk) disable iff (rst)
        (dm && !start_any) |=> (dm || !dqs_en));

    // R9: a rejected command leaves the open/closed state untouched
    a_r9_err_keeps_state: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> (open_v == $past(open_v)));

    // R2: an accepted activate opens its bank
    a_r2_act_opens: assert property (@(posedge clk) disable iff (rst)
        go_act |=> open_v[$past(cmd_bank)]);

endmodule

bind ddr_wr_pre_guard ddr_wr_pre_guard_chk #(
    .NB (NUM_BANKS),
    .BW (BANK_W),
    .BL (BURST_LEN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dqs_en    (dqs_en),
    .dm        (dm),
    .start_any (start_any),
    .go_act    (go_act),
    .cmd_bank  (cmd_bank),
    .open_v    (open_v),
    .proto_err (proto_err)
);

// File: tb/ddr_wr_pre_guard_tb.sv
module ddr_wr_pre_guard_tb;
    localparam int NB = 4, BW = 2, BL = 8, TWR = 3, TRP = 3, TRAS = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    cmd_op = 3'd0;
    logic [BW-1:0] cmd_bank = '0;
    logic [NB-1:0] pre_ok, act_ok;
    logic          dqs_en, dm, proto_err;

    always #5 clk = ~clk;

    ddr_wr_pre_guard #(
        .NUM_BANKS (NB), .BANK_W (BW), .BURST_LEN (BL),
        .T_WR (TWR), .T_RP (TRP), .T_RAS (TRAS)
    ) u_dut (
        .clk (clk), .rst (rst), .cmd_op (cmd_op), .cmd_bank (cmd_bank),
        .pre_ok (pre_ok), .act_ok (act_ok), .dqs_en (dqs_en), .dm (dm),
        .proto_err (proto_err)
    );

    int    n_chk = 0, n_bad = 0, e = 0;
    string tag = "R1";
    int    m_open [NB];
    int    ras_r [NB];
    int    wr_r [NB];
    int    act_r [NB];
    int    b_start = -100, b_bank = 0, b_cut = -1;
    bit    b_auto = 1'b0, err_m = 1'b0;

    function automatic bit win(int x, int b);
        return !b_auto && b_cut < 0 && b_bank == b && x > b_start && x <= b_start + BL - 1;
    endfunction

    task automatic chk(string f, logic [NB-1:0] got, logic [NB-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got %b exp %b", tag, f, got, exp);
        end
    endtask

    task automatic compare();
        logic [NB-1:0] ep, ea;
        for (int b = 0; b < NB; b++) begin
            ep[b] = m_open[b] != 0 && e + 1 >= ras_r[b] && (e + 1 >= wr_r[b] || win(e + 1, b));
            ea[b] = m_open[b] == 0 && e + 1 >= act_r[b];
        end
        chk("pre_ok", pre_ok, ep);
        chk("act_ok", act_ok, ea);
        chk("dqs_en", NB'(dqs_en), NB'(e >= b_start && e <= b_start + BL - 1));
        chk("dm", NB'(dm), NB'(b_cut >= 0 && e >= b_cut && e <= b_start + BL - 1));
        chk("proto_err", NB'(proto_err), NB'(err_m));
    endtask

    task automatic model(int op, int b);
        int span;
        bit live = (b_start + BL - 1) >= e;
        err_m = (op == 1 && m_open[b] != 0)
             || ((op == 2 || op == 3 || op == 4) && m_open[b] == 0)
             || ((op == 2 || op == 3) && b_auto && live);
        if (err_m) return;
        case (op)
            1: begin m_open[b] = 1; ras_r[b] = e + TRAS; wr_r[b] = 0; end
            2, 3: begin
                if (win(e, b_bank) && b_bank != b) wr_r[b_bank] = e + TWR;
                if (op == 2) wr_r[b] = e + BL + TWR;
                else begin
                    span = (ras_r[b] - e > BL + TWR) ? ras_r[b] - e : BL + TWR;
                    act_r[b] = e + span + TRP;
                    m_open[b] = 0;
                end
                b_start = e; b_bank = b; b_cut = -1; b_auto = (op == 3);
            end
            4: begin
                if (win(e, b)) begin b_cut = e; act_r[b] = e + TWR + TRP; end
                else act_r[b] = e + TRP;
                m_open[b] = 0;
            end
            default: ;
        endcase
    endtask

    task automatic step(int op, int b);
        cmd_op = 3'(op);
        cmd_bank = BW'(b);
        @(posedge clk);
        e++;
        model(op, b);
        @(negedge clk);
        cmd_op = 3'd0;
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_open[b] = 0; ras_r[b] = 0; wr_r[b] = 0; act_r[b] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        tag = "R1"; compare();
        tag = "R10"; step(7, 1); step(5, 0); step(6, 3);
        tag = "R2"; step(1, 0); idle(16);
        tag = "R4"; step(2, 0); idle(13);
        tag = "R7"; step(4, 0); idle(4);
        tag = "R9"; step(2, 1); step(4, 2); step(1, 0); step(1, 0); idle(2);
        tag = "R5"; step(1, 1); step(1, 2); idle(15);
        step(2, 1); idle(2); step(2, 2); idle(3); step(2, 2); idle(12);
        step(4, 1); step(4, 2); idle(4);
        tag = "R6"; step(1, 3); idle(15); step(2, 3); idle(3); step(4, 3); idle(10);
        step(1, 1); idle(15); step(2, 1); idle(2); step(4, 1); step(2, 0); idle(12);
        tag = "R8"; step(1, 3); step(3, 3); idle(20);
        step(1, 3); idle(15); step(3, 3);
        tag = "R9"; step(2, 0); idle(18);
        tag = "R3"; step(2, 0); idle(12);
        finish_run();
    end

endmodule